// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller with Watchdog NMI

This block gathers eight maskable interrupt request lines and one non-maskable request raised by a watchdog overflow. It keeps a pending-flag register, an enable register and a master enable bit. At every instruction boundary it tells the CPU whether to take an interrupt and which vector address to fetch. The CPU's instruction decoder drives four control pulses into it: enable-interrupts, disable-interrupts, return from a maskable handler and return from the non-maskable handler.

Request line n sets pending bit n. A maskable request is taken only when the master enable and its own enable bit are both set. A request that is not enabled stays pending until both become set. The non-maskable request ignores both enables. Priority is fixed and the vectors are eight bytes apart. The master enable is saved on entry to the non-maskable handler and put back on its return, unless the handler ran enable or disable itself. In that case the last such instruction decides the value.

A three-state machine tracks the non-maskable handler. `ST_RUN` means no handler is active. `ST_NMI_CLEAN` means the handler is active and has not touched the master enable. `ST_NMI_TOUCHED` means the handler is active and has executed enable or disable. Transitions: `ST_RUN` goes to `ST_NMI_CLEAN` when the NMI is accepted. `ST_NMI_CLEAN` goes to `ST_NMI_TOUCHED` on an enable or disable pulse. Either handler state returns to `ST_RUN` on the NMI-return pulse, and that transition takes precedence over the move to the touched state.

Top module: `vec_irq_ctrl`

## Requirements
- R1: After reset the pending flags, enable bits and master enable (`ime_o`) read 0. No NMI is pending, the machine is in `ST_RUN`, and `take_o` stays low at any boundary until a request arrives.
- R2: A pulse on `irq_evt[n]` sets pending bit n. A write to address 0xFFFE replaces the pending register with the write data, so writing a 0 clears a pending bit. A bit whose event pulses in the same cycle still ends at 1. Reading 0xFFFE returns the pending register.
- R3: The enable register is read and written at address 0xFFFF, and bit n enables line n. Any other address reads 0, and a write to it changes nothing.
- R4: `take_o` rises only in a cycle with `insn_done` high. A maskable request is taken only when `ime_o` is 1 and the AND of the pending and enable registers is nonzero. A request that is not enabled stays pending and is taken at the first boundary after both enables are 1.
- R5: Priority is fixed: NMI first, then line 0, then line 7 last. Only one request is taken per boundary. While `take_o` is high, `vec_o` is 0x0080 for the NMI and 0x0040 + 8·n for line n. While `take_o` is low, `vec_o` is 0.
- R6: Taking a maskable request clears its pending bit, unless the same line pulses in that cycle. It also clears the master enable, overriding any enable, disable or return pulse in the same cycle.
- R7: When no request is taken, `di` clears the master enable. Otherwise `ei` or `reti` sets it, and `di` wins over both.
- R8: A pulse on `nmi_evt` makes the NMI pending. It is taken at the next boundary in `ST_RUN` whatever the master enable and enable bits hold. It is never taken again while a handler is active, and a pulse that arrives during the handler waits until `nreti`.
- R9: Taking the NMI saves the master enable, clears it, and moves to `ST_NMI_CLEAN`. If no other master-enable control arrives in the same cycle, `nreti` in that state restores the saved value.
- R10: `ei` or `di` inside the handler moves to `ST_NMI_TOUCHED`. `nreti` from there leaves the master enable at the value the last `ei` or `di` gave it. `nreti` in `ST_RUN` has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_evt | input | 8 | One-cycle request pulses, one per maskable line |
| nmi_evt | input | 1 | One-cycle watchdog overflow pulse |
| insn_done | input | 1 | Instruction boundary strobe |
| ei | input | 1 | Enable-interrupts pulse from the decoder |
| di | input | 1 | Disable-interrupts pulse from the decoder |
| reti | input | 1 | Return from a maskable handler |
| nreti | input | 1 | Return from the NMI handler |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 16 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational) |
| take_o | output | 1 | Interrupt accepted at this boundary |
| vec_o | output | 16 | Vector address of the accepted interrupt |
| ime_o | output | 1 | Master interrupt enable |

## Verification
A corrupted pending or enable bit shows up on `reg_rdata` in the same cycle. It also shows up at the next boundary as a request that is taken when it should not be, or one that is missed. A wrong master enable or handler state shows on `ime_o` one cycle after the decoder pulse or the NMI return that exposes it, and it also changes which boundaries raise `take_o`. The bench compares every cycle against a model built from the requirements, so each such fault is caught at its first visible cycle.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
    typedef enum logic [1:0] {
        ST_RUN         = 2'd0,
        ST_NMI_CLEAN   = 2'd1,
        ST_NMI_TOUCHED = 2'd2
    } nmi_state_t;
endpackage

// File: rtl/irqc_regs.sv
module irqc_regs #(
    parameter int          N_IRQ   = 8,
    parameter int          ADDR_W  = 16,
    parameter logic [15:0] IF_ADDR = 16'hFFFE,
    parameter logic [15:0] IE_ADDR = 16'hFFFF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_IRQ-1:0]  irq_evt,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [N_IRQ-1:0]  wdata,
    input  logic [N_IRQ-1:0]  clr_mask,
    output logic [N_IRQ-1:0]  flag_q,
    output logic [N_IRQ-1:0]  en_q,
    output logic [N_IRQ-1:0]  rdata
);
    localparam logic [ADDR_W-1:0] FLAG_A = ADDR_W'(IF_ADDR);
    localparam logic [ADDR_W-1:0] EN_A   = ADDR_W'(IE_ADDR);

    logic             hit_flag;
    logic             hit_en;
    logic [N_IRQ-1:0] flag_base;
    logic [N_IRQ-1:0] flag_d;

    assign hit_flag = (addr == FLAG_A);
    assign hit_en   = (addr == EN_A);

    always_comb begin
        flag_base = (wr_en && hit_flag) ? wdata : flag_q;
        flag_d    = (flag_base & ~clr_mask) | irq_evt;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_q <= '0;
            en_q   <= '0;
        end else begin
            flag_q <= flag_d;
            if (wr_en && hit_en) begin
                en_q <= wdata;
            end
        end
    end

    always_comb begin
        if (hit_flag) begin
            rdata = flag_q;
        end else if (hit_en) begin
            rdata = en_q;
        end else begin
            rdata = '0;
        end
    end
endmodule

// File: rtl/irqc_prio.sv
module irqc_prio #(
    parameter int          N_IRQ    = 8,
    parameter int          VEC_W    = 16,
    parameter logic [15:0] VEC_BASE = 16'h0040,
    parameter int          VEC_STEP = 8,
    parameter logic [15:0] NMI_VEC  = 16'h0080
) (
    input  logic [N_IRQ-1:0] pend,
    input  logic             ime,
    input  logic             nmi_ready,
    input  logic             boundary,
    output logic             take_nmi,
    output logic             take_mask,
    output logic [N_IRQ-1:0] grant,
    output logic [VEC_W-1:0] vec
);
    logic [N_IRQ:0]   blocked;
    logic [N_IRQ-1:0] raw_grant;
    logic [VEC_W-1:0] vec_mask;

    assign blocked[0] = 1'b0;

    genvar g;
    generate
        for (g = 0; g < N_IRQ; g++) begin : g_chain
            assign raw_grant[g]   = pend[g] & ~blocked[g];
            assign blocked[g + 1] = blocked[g] | pend[g];
        end
    endgenerate

    assign take_nmi  = boundary & nmi_ready;
    assign take_mask = boundary & ime & blocked[N_IRQ] & ~take_nmi;
    assign grant     = take_mask ? raw_grant : '0;

    always_comb begin
        vec_mask = '0;
        for (int i = 0; i < N_IRQ; i++) begin
            if (raw_grant[i]) begin
                vec_mask = vec_mask | VEC_W'(int'(VEC_BASE) + i * VEC_STEP);
            end
        end
    end

    always_comb begin
        if (take_nmi) begin
            vec = VEC_W'(NMI_VEC);
        end else if (take_mask) begin
            vec = vec_mask;
        end else begin
            vec = '0;
        end
    end
endmodule

// File: rtl/irqc_fsm.sv
module irqc_fsm
    import irqc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       nmi_evt,
    input  logic       take_nmi,
    input  logic       take_mask,
    input  logic       ei,
    input  logic       di,
    input  logic       reti,
    input  logic       nreti,
    output logic       ime,
    output logic       saved_ime,
    output logic       nmi_ready,
    output nmi_state_t state
);
    nmi_state_t state_d;
    logic       ime_d;
    logic       saved_d;
    logic       nmi_pend_q;
    logic       nmi_pend_d;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= ST_RUN;
            ime        <= 1'b0;
            saved_ime  <= 1'b0;
            nmi_pend_q <= 1'b0;
        end else begin
            state      <= state_d;
            ime        <= ime_d;
            saved_ime  <= saved_d;
            nmi_pend_q <= nmi_pend_d;
        end
    end

    always_comb begin
        state_d = state;
        unique case (state)
            ST_RUN: begin
                if (take_nmi) state_d = ST_NMI_CLEAN;
            end
            ST_NMI_CLEAN: begin
                if (nreti)          state_d = ST_RUN;
                else if (ei || di)  state_d = ST_NMI_TOUCHED;
            end
            ST_NMI_TOUCHED: begin
                if (nreti) state_d = ST_RUN;
            end
            default: state_d = ST_RUN;
        endcase
    end

    always_comb begin
        nmi_ready  = nmi_pend_q && (state == ST_RUN);
        nmi_pend_d = nmi_evt | (nmi_pend_q & ~take_nmi);
        saved_d    = take_nmi ? ime : saved_ime;
        if (take_mask || take_nmi) begin
            ime_d = 1'b0;
        end else if (di) begin
            ime_d = 1'b0;
        end else if (ei || reti) begin
            ime_d = 1'b1;
        end else if (nreti && state == ST_NMI_CLEAN) begin
            ime_d = saved_ime;
        end else begin
            ime_d = ime;
        end
    end
endmodule

// File: rtl/vec_irq_ctrl.sv
module vec_irq_ctrl
    import irqc_pkg::*;
#(
    parameter int          N_IRQ    = 8,
    parameter int          ADDR_W   = 16,
    parameter int          VEC_W    = 16,
    parameter logic [15:0] IF_ADDR  = 16'hFFFE,
    parameter logic [15:0] IE_ADDR  = 16'hFFFF,
    parameter logic [15:0] VEC_BASE = 16'h0040,
    parameter int          VEC_STEP = 8,
    parameter logic [15:0] NMI_VEC  = 16'h0080
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_IRQ-1:0]  irq_evt,
    input  logic              nmi_evt,
    input  logic              insn_done,
    input  logic              ei,
    input  logic              di,
    input  logic              reti,
    input  logic              nreti,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [N_IRQ-1:0]  reg_wdata,
    output logic [N_IRQ-1:0]  reg_rdata,
    output logic              take_o,
    output logic [VEC_W-1:0]  vec_o,
    output logic              ime_o
);
    logic [N_IRQ-1:0] flag_q;
    logic [N_IRQ-1:0] en_q;
    logic [N_IRQ-1:0] grant;
    logic             take_nmi;
    logic             take_mask;
    logic             nmi_ready;
    logic             saved_ime;
    nmi_state_t       nmi_state;

    irqc_regs #(
        .N_IRQ  (N_IRQ),
        .ADDR_W (ADDR_W),
        .IF_ADDR(IF_ADDR),
        .IE_ADDR(IE_ADDR)
    ) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .irq_evt (irq_evt),
        .wr_en   (reg_wr),
        .addr    (reg_addr),
        .wdata   (reg_wdata),
        .clr_mask(grant),
        .flag_q  (flag_q),
        .en_q    (en_q),
        .rdata   (reg_rdata)
    );

    irqc_prio #(
        .N_IRQ   (N_IRQ),
        .VEC_W   (VEC_W),
        .VEC_BASE(VEC_BASE),
        .VEC_STEP(VEC_STEP),
        .NMI_VEC (NMI_VEC)
    ) u_prio (
        .pend     (flag_q & en_q),
        .ime      (ime_o),
        .nmi_ready(nmi_ready),
        .boundary (insn_done),
        .take_nmi (take_nmi),
        .take_mask(take_mask),
        .grant    (grant),
        .vec      (vec_o)
    );

    irqc_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .nmi_evt  (nmi_evt),
        .take_nmi (take_nmi),
        .take_mask(take_mask),
        .ei       (ei),
        .di       (di),
        .reti     (reti),
        .nreti    (nreti),
        .ime      (ime_o),
        .saved_ime(saved_ime),
        .nmi_ready(nmi_ready),
        .state    (nmi_state)
    );

    assign take_o = take_nmi | take_mask;
endmodule

// File: rtl/irqc_checker.sv
module irqc_checker
    import irqc_pkg::*;
#(
    parameter int          VEC_W    = 16,
    parameter logic [15:0] NMI_VEC  = 16'h0080
) (
    input logic             clk,
    input logic             rst_n,
    input logic             insn_done,
    input logic             ei,
    input logic             di,
    input logic             reti,
    input logic             nreti,
    input logic             take_o,
    input logic [VEC_W-1:0] vec_o,
    input logic             ime_o,
    input logic             saved_ime,
    input nmi_state_t       nmi_state
);
    logic is_nmi;
    assign is_nmi = (vec_o == VEC_W'(NMI_VEC));

    AST_TAKE_AT_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
        take_o |-> insn_done); // R4
    AST_MASKABLE_NEEDS_IME: assert property (@(posedge clk) disable iff (!rst_n)
        (take_o && !is_nmi) |-> ime_o); // R4
    AST_IDLE_VEC_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !take_o |-> (vec_o == '0)); // R5
    AST_ACCEPT_DROPS_IME: assert property (@(posedge clk) disable iff (!rst_n)
        (take_o && !is_nmi) |=> !ime_o); // R6
    AST_DI_CLEARS_IME: assert property (@(posedge clk) disable iff (!rst_n)
        di |=> !ime_o); // R7
    AST_EI_SETS_IME: assert property (@(posedge clk) disable iff (!rst_n)
        (ei && !di && !take_o) |=> ime_o); // R7
    AST_NO_NMI_REENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        (take_o && nmi_state != ST_RUN) |-> !is_nmi); // R8
    AST_NMI_ENTERS_HANDLER: assert property (@(posedge clk) disable iff (!rst_n)
        (take_o && is_nmi) |=> (nmi_state == ST_NMI_CLEAN && !ime_o)); // R9
    AST_CLEAN_RETURN_RESTORES: assert property (@(posedge clk) disable iff (!rst_n)
        (nreti && nmi_state == ST_NMI_CLEAN && !take_o && !ei && !di && !reti)
        |=> (ime_o == $past(saved_ime))); // R9
    AST_TOUCHED_RETURN_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (nreti && nmi_state == ST_NMI_TOUCHED && !take_o && !ei && !di && !reti)
        |=> $stable(ime_o)); // R10
endmodule

bind vec_irq_ctrl irqc_checker #(
    .VEC_W  (VEC_W),
    .NMI_VEC(NMI_VEC)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .insn_done(insn_done),
    .ei       (ei),
    .di       (di),
    .reti     (reti),
    .nreti    (nreti),
    .take_o   (take_o),
    .vec_o    (vec_o),
    .ime_o    (ime_o),
    .saved_ime(saved_ime),
    .nmi_state(nmi_state)
);

// File: tb/vec_irq_ctrl_tb.sv
module vec_irq_ctrl_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  irq_evt = '0;
    logic        nmi_evt = 1'b0;
    logic        insn_done = 1'b0;
    logic        ei = 1'b0, di = 1'b0, reti = 1'b0, nreti = 1'b0;
    logic        reg_wr = 1'b0;
    logic [15:0] reg_addr = 16'h0000;
    logic [7:0]  reg_wdata = '0;
    logic [7:0]  reg_rdata;
    logic        take_o;
    logic [15:0] vec_o;
    logic        ime_o;

    int n_chk = 0;
    int n_bad = 0;

    // model state, built from the requirements
    logic [7:0] m_if = '0, m_ie = '0;
    logic       m_ime = 0, m_np = 0, m_saved = 0;
    int         m_st = 0; // 0 run, 1 handler clean, 2 handler touched

    always #10 clk = ~clk; // 50 MHz

    vec_irq_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .irq_evt(irq_evt), .nmi_evt(nmi_evt),
        .insn_done(insn_done), .ei(ei), .di(di), .reti(reti), .nreti(nreti),
        .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .take_o(take_o), .vec_o(vec_o), .ime_o(ime_o)
    );

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic int lowest(input logic [7:0] v);
        for (int i = 0; i < 8; i++) if (v[i]) return i;
        return 0;
    endfunction

    function automatic logic [7:0] exp_rd(input logic [15:0] a);
        if (a == 16'hFFFE) return m_if;   // R2
        if (a == 16'hFFFF) return m_ie;   // R3
        return 8'h00;                     // R3
    endfunction

    task automatic clear_inputs();
        irq_evt = '0; nmi_evt = 0; insn_done = 0;
        ei = 0; di = 0; reti = 0; nreti = 0; reg_wr = 0;
    endtask

    // check the current cycle, then advance the model across the edge
    task automatic cyc();
        logic       e_tn, e_tm, n_ime, n_np, n_saved;
        logic [7:0] base, n_if, n_ie;
        logic [15:0] e_vec;
        int         idx, n_st;
        #2;
        e_tn  = insn_done && m_np && (m_st == 0);
        e_tm  = insn_done && m_ime && ((m_if & m_ie) != 0) && !e_tn;
        idx   = lowest(m_if & m_ie);
        e_vec = e_tn ? 16'h0080 : (e_tm ? 16'(16'h0040 + 8 * idx) : 16'h0000);
        check(e_tn ? "R8 take" : "R4 take", {15'd0, take_o}, {15'd0, e_tn | e_tm});
        check("R5 vector", vec_o, e_vec);
        check("R1 R7 R9 R10 master enable", {15'd0, ime_o}, {15'd0, m_ime});
        check("R2 R3 readback", {8'd0, reg_rdata}, {8'd0, exp_rd(reg_addr)});
        base = (reg_wr && reg_addr == 16'hFFFE) ? reg_wdata : m_if;
        if (e_tm) base[idx] = 1'b0;                 // R6
        n_if = base | irq_evt;
        n_ie = (reg_wr && reg_addr == 16'hFFFF) ? reg_wdata : m_ie;
        n_np = nmi_evt | (m_np & ~e_tn);
        n_saved = e_tn ? m_ime : m_saved;
        if (e_tn || e_tm)                n_ime = 0;
        else if (di)                     n_ime = 0;
        else if (ei || reti)             n_ime = 1;
        else if (nreti && m_st == 1)     n_ime = m_saved;
        else                             n_ime = m_ime;
        if (e_tn)                        n_st = 1;
        else if (nreti && m_st != 0)     n_st = 0;
        else if ((ei || di) && m_st == 1) n_st = 2;
        else                             n_st = m_st;
        @(posedge clk);
        m_if = n_if; m_ie = n_ie; m_np = n_np; m_saved = n_saved;
        m_ime = n_ime; m_st = n_st;
        @(negedge clk);
        clear_inputs();
    endtask

    task automatic wr(input logic [15:0] a, input logic [7:0] d);
        reg_wr = 1; reg_addr = a; reg_wdata = d; cyc();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual running expected finished");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd2024));
        // R1: reset state
        repeat (3) @(negedge clk);
        reg_addr = 16'hFFFE; #2;
        check("R1 IF at reset", {8'd0, reg_rdata}, 16'h0000);
        check("R1 ime at reset", {15'd0, ime_o}, 16'h0000);
        rst_n = 1;
        insn_done = 1; reg_addr = 16'hFFFF; cyc();

        // R2 R4: pending lines 3 and 5 with nothing enabled stay pending
        irq_evt = 8'h28; ei = 1; cyc();
        insn_done = 1; reg_addr = 16'hFFFE; cyc();
        insn_done = 1; reg_addr = 16'hFFFE; cyc();
        // R3: a write to an unused address changes nothing
        wr(16'hFFFD, 8'hFF);
        reg_addr = 16'hFFFF; cyc();
        // R4 R5 R6: enabling picks line 3 first, then line 5 after ei
        wr(16'hFFFF, 8'h28);
        insn_done = 1; reg_addr = 16'hFFFE; cyc();
        insn_done = 1; cyc();
        ei = 1; cyc();
        insn_done = 1; cyc();
        // R2: write-to-clear, and event wins over a same-cycle write of 0
        irq_evt = 8'h81; cyc();
        reg_wr = 1; reg_addr = 16'hFFFE; reg_wdata = 8'h00; irq_evt = 8'h01; cyc();
        reg_addr = 16'hFFFE; cyc();
        // R8 R9: NMI beats a pending enabled line; IME restored on return
        wr(16'hFFFF, 8'hFF);
        ei = 1; nmi_evt = 1; cyc();
        insn_done = 1; cyc();
        nmi_evt = 1; insn_done = 1; cyc();      // R8 no re-entry
        insn_done = 1; cyc();
        nreti = 1; cyc();                        // R9 restore 1
        insn_done = 1; cyc();                    // second NMI now
        // R10: DI inside the handler wins over the saved value
        di = 1; cyc();
        ei = 1; cyc();
        di = 1; cyc();
        nreti = 1; cyc();
        insn_done = 1; cyc();
        nreti = 1; ei = 1; cyc();                // R10 nreti in run ignored
        reti = 1; cyc();                         // R7

        // constrained random
        for (int k = 0; k < 3000; k++) begin
            irq_evt   = 8'($urandom) & 8'($urandom) & 8'($urandom) & 8'($urandom);
            nmi_evt   = ($urandom % 64) == 0;
            insn_done = ($urandom % 2) == 0;
            ei        = ($urandom % 10) == 0;
            di        = ($urandom % 12) == 0;
            reti      = ($urandom % 20) == 0;
            nreti     = ($urandom % 10) == 0;
            reg_wr    = ($urandom % 12) == 0;
            case ($urandom % 3)
                0: reg_addr = 16'hFFFE;
                1: reg_addr = 16'hFFFF;
                default: reg_addr = 16'(16'hFF00 + ($urandom % 254));
            endcase
            reg_wdata = 8'($urandom);
            cyc();
        end

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule